// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

A full-duplex asynchronous serial port for one line pair. The transmitter turns a character of 5 to 9 data bits into a serial frame. The frame has a low start bit, the data least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The receiver rebuilds characters from the incoming line. Both directions run from one shared oversampling tick. A 12-bit divisor sets the tick to `cfg_div + 1` clock cycles. A bit lasts 16 ticks, or 8 ticks when double speed is selected.

Software-side access uses strobes. A one-entry holding register accepts a byte only while it is empty. The ninth data bit lives in a separate bit that is loaded before the byte. The receive side keeps the last character together with its ninth bit, a frame-error flag and a parity-error flag. The receiver checks the start bit first. It then decides each bit by a majority of three mid-bit samples, checks parity when this is enabled, and checks only the first stop bit.

Top module: `sfx_xcvr`

## Requirements
- R1: After reset: `txd` is 1, `tx_empty` is 1, and `tx_done`, `rx_full`, `err_frame` and `err_parity` are 0.
- R2: A transmitted frame has these bits in order: start 0, then `cfg_len` data bits with the least significant first, then parity if enabled, then one stop bit of value 1, or two if `cfg_two_stop` is 1. Each bit lasts 16×(`cfg_div`+1) clock cycles, or 8×(`cfg_div`+1) when `cfg_dbl` is 1. A `cfg_len` below 5 acts as 5 and above 9 acts as 9.
- R3: The parity bit sits between the last data bit and the first stop bit. With `cfg_par_odd`=0 it is the XOR of the data bits. With `cfg_par_odd`=1 it is the inverse of that XOR.
- R4: `wr_stb` loads `wr_byte` only while `tx_empty` is 1, and `tx_empty` then goes to 0. A write while `tx_empty` is 0 is ignored. The held character moves to the shifter on a tick when the line is idle, or at the end of the current frame.
- R5: The ninth data bit sent is the value of `ninth_in` at the last `ninth_wr` before the data write. A later `ninth_wr` does not change a character that is already accepted.
- R6: `tx_done` rises at the end of the last stop bit when no character is waiting. It stays 0 between back-to-back frames. `txdone_clr` clears it.
- R7: The receiver takes samples 8, 9 and 10 of the 16 per bit, or samples 4, 5 and 6 of the 8 per bit in double speed. Each bit is the majority of its three samples. At the end of a frame, `rd_byte` holds data bits 7..0, `rd_ninth` holds bit 8 (0 for shorter characters), and `rx_full` is set.
- R8: A low level that is high again at the start bit's middle samples is dropped. No character results.
- R9: `err_frame` is set when the first stop bit is sampled low. The receiver ignores `cfg_two_stop`, so a frame with one stop bit followed at once by the next start bit is received without error.
- R10: `err_parity` is set when the received parity bit does not match the rule in R3. It is always 0 when `cfg_par_en` is 0.
- R11: `rd_stb` clears `rx_full`. The data and error outputs keep their values until the next character arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 12 | Tick divisor; tick period is cfg_div+1 cycles |
| cfg_dbl | input | 1 | Double speed: 8 ticks per bit instead of 16 |
| cfg_len | input | 4 | Data bits per character, 5 to 9 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Transmitter sends two stop bits |
| wr_stb | input | 1 | Write strobe for the transmit byte |
| wr_byte | input | 8 | Transmit data bits 7..0 |
| ninth_wr | input | 1 | Load strobe for the transmit ninth bit |
| ninth_in | input | 1 | Transmit ninth bit value |
| txdone_clr | input | 1 | Clears tx_done |
| rd_stb | input | 1 | Read strobe; clears rx_full |
| rd_byte | output | 8 | Received data bits 7..0 |
| rd_ninth | output | 1 | Received data bit 8 |
| tx_empty | output | 1 | Holding register can accept a byte |
| tx_done | output | 1 | Frame finished and nothing waiting |
| rx_full | output | 1 | A received character is present |
| err_frame | output | 1 | Stop bit of the held character was low |
| err_parity | output | 1 | Parity of the held character was wrong |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |

## Verification
The transmit line changes only on a tick. The bench therefore finds the falling edge of the start bit and samples each later bit half a bit period into it. It then samples every P = ticks×(`cfg_div`+1) cycles, so no sample falls near a transition. `tx_done` is due at the end of the last stop bit, so it is checked a few cycles past that point. The receiver runs one tick plus two synchroniser stages behind the line, and it finishes at the decision sample of the stop bit. Its results are therefore polled, with a limit of a few bit periods. The "no character" checks (an ignored write, a dropped glitch) wait two full frame times before they look at `rx_full`.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  localparam int FRM_W = 13;   // start + 9 data + parity + 2 stop

  typedef struct packed {
    logic [FRM_W-1:0] bits;    // LSB leaves first
    logic [3:0]       nbits;
  } frame_t;

  typedef enum logic [2:0] {
    RS_IDLE, RS_START, RS_DATA, RS_PAR, RS_STOP
  } rx_state_t;

  function automatic logic [3:0] len_clamp(input logic [3:0] l);
    if (l < 4'd5)      return 4'd5;
    else if (l > 4'd9) return 4'd9;
    else               return l;
  endfunction

  function automatic logic parity_of(input logic [8:0] d, input logic [3:0] len,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 9; i++)
      if (4'(i) < len) p = p ^ d[i];
    return p;
  endfunction

  function automatic frame_t build_frame(input logic [8:0] d, input logic [3:0] len,
                                         input logic pen, input logic odd,
                                         input logic two);
    frame_t     f;
    logic [3:0] pos;
    f.bits    = '1;
    f.bits[0] = 1'b0;
    pos       = 4'd1;
    for (int i = 0; i < 9; i++) begin
      if (4'(i) < len) begin
        f.bits[pos] = d[i];
        pos = pos + 4'd1;
      end
    end
    if (pen) begin
      f.bits[pos] = parity_of(d, len, odd);
      pos = pos + 4'd1;
    end
    f.nbits = pos + 4'd1 + {3'b000, two};
    return f;
  endfunction

endpackage

// File: rtl/sfx_baud.sv
module sfx_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == '0);
    cnt_d = tick ? div : cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
  import sfx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       dbl,
  input  logic [3:0] len,
  input  logic       pen,
  input  logic       odd,
  input  logic       two,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       ninth_wr,
  input  logic       ninth_in,
  input  logic       done_clr,
  output logic       txd,
  output logic       empty,
  output logic       done,
  output logic       busy,
  output logic [8:0] hold_o
);

  localparam int CW = $clog2(OVS);

  logic [8:0]       hold_q, hold_d;
  logic             full_q, full_d;
  logic             ninth_q, ninth_d;
  logic             busy_q, busy_d;
  logic [FRM_W-1:0] sh_q, sh_d;
  logic [3:0]       left_q, left_d;
  logic [CW-1:0]    sub_q, sub_d;
  logic             done_q, done_d;

  logic [CW-1:0] last_sub;
  logic          wr_ok, end_bit, last, load;
  frame_t        nf;

  always_comb begin
    last_sub = dbl ? CW'(OVS/2 - 1) : CW'(OVS - 1);
    nf       = build_frame(hold_q, len_clamp(len), pen, odd, two);
    wr_ok    = wr_stb & ~full_q;
    end_bit  = tick & busy_q & (sub_q == last_sub);
    last     = end_bit & (left_q == 4'd1);
    load     = tick & full_q & (~busy_q | last);

    hold_d  = hold_q;
    full_d  = full_q;
    ninth_d = ninth_q;
    busy_d  = busy_q;
    sh_d    = sh_q;
    left_d  = left_q;
    sub_d   = sub_q;
    done_d  = done_q;

    if (ninth_wr) ninth_d = ninth_in;
    if (done_clr) done_d = 1'b0;
    if (wr_ok) begin
      hold_d = {ninth_q, wr_byte};
      full_d = 1'b1;
    end
    if (tick & busy_q) sub_d = end_bit ? '0 : sub_q + CW'(1);
    if (end_bit) begin
      sh_d   = {1'b1, sh_q[FRM_W-1:1]};
      left_d = left_q - 4'd1;
    end
    if (last & ~full_q) begin
      busy_d = 1'b0;
      done_d = ~wr_ok;
    end
    if (load) begin
      sh_d   = nf.bits;
      left_d = nf.nbits;
      sub_d  = '0;
      busy_d = 1'b1;
      full_d = 1'b0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      ninth_q <= 1'b0;
      busy_q  <= 1'b0;
      sh_q    <= '1;
      left_q  <= '0;
      sub_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      full_q  <= full_d;
      ninth_q <= ninth_d;
      busy_q  <= busy_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
      sub_q   <= sub_d;
      done_q  <= done_d;
    end
  end

  assign txd    = ~busy_q | sh_q[0];
  assign empty  = ~full_q;
  assign done   = done_q;
  assign busy   = busy_q;
  assign hold_o = hold_q;

endmodule

// File: rtl/sfx_rx.sv
module sfx_rx
  import sfx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       dbl,
  input  logic [3:0] len,
  input  logic       pen,
  input  logic       odd,
  input  logic       rxd,
  input  logic       rd_stb,
  output logic [8:0] rx_word,
  output logic       full,
  output logic       ferr,
  output logic       perr,
  output logic       fin
);

  localparam int CW = $clog2(OVS + 1);

  logic          s1_q, s2_q;
  rx_state_t     st_q, st_d;
  logic [CW-1:0] sub_q, sub_d;
  logic [1:0]    vote_q, vote_d;
  logic [3:0]    idx_q, idx_d;
  logic [8:0]    dat_q, dat_d;
  logic          pb_q, pb_d;
  logic [3:0]    len_q, len_d;
  logic          pen_q, pen_d, odd_q, odd_d;
  logic [8:0]    buf_q, buf_d;
  logic          full_q, full_d, fe_q, fe_d, pe_q, pe_d;

  logic [CW-1:0] lim, mid, s;
  logic          maj, decide, wrap, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    lim    = dbl ? CW'(OVS/2) : CW'(OVS);
    mid    = lim >> 1;
    s      = sub_q + CW'(1);
    active = (st_q != RS_IDLE);
    maj    = (vote_q[0] & vote_q[1]) | (vote_q[0] & s2_q) | (vote_q[1] & s2_q);
    decide = tick & active & (s == mid + CW'(2));
    wrap   = tick & active & (s == lim);
    fin    = decide & (st_q == RS_STOP);

    st_d   = st_q;   sub_d  = sub_q;  vote_d = vote_q; idx_d = idx_q;
    dat_d  = dat_q;  pb_d   = pb_q;   len_d  = len_q;  pen_d = pen_q;
    odd_d  = odd_q;  buf_d  = buf_q;  full_d = full_q; fe_d  = fe_q;
    pe_d   = pe_q;

    if (rd_stb) full_d = 1'b0;

    if (tick) begin
      if (!active) begin
        if (!s2_q) begin
          st_d  = RS_START;
          sub_d = CW'(1);
          dat_d = '0;
          idx_d = '0;
          len_d = len_clamp(len);
          pen_d = pen;
          odd_d = odd;
        end
      end else begin
        sub_d = wrap ? '0 : s;
        if (s == mid)          vote_d[0] = s2_q;
        if (s == mid + CW'(1)) vote_d[1] = s2_q;
      end
    end

    if (decide) begin
      case (st_q)
        RS_START: if (maj) begin st_d = RS_IDLE; sub_d = '0; end
        RS_DATA:  dat_d[idx_q] = maj;
        RS_PAR:   pb_d = maj;
        RS_STOP: begin
          st_d   = RS_IDLE;
          sub_d  = '0;
          full_d = 1'b1;
          buf_d  = dat_q;
          fe_d   = ~maj;
          pe_d   = pen_q & (pb_q ^ parity_of(dat_q, len_q, odd_q));
        end
        default: ;
      endcase
    end

    if (wrap) begin
      case (st_q)
        RS_START: begin st_d = RS_DATA; idx_d = '0; end
        RS_DATA: begin
          idx_d = idx_q + 4'd1;
          if (idx_q == len_q - 4'd1) st_d = pen_q ? RS_PAR : RS_STOP;
        end
        RS_PAR:  st_d = RS_STOP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RS_IDLE; sub_q <= '0; vote_q <= '0; idx_q <= '0;
      dat_q <= '0; pb_q <= 1'b0; len_q <= 4'd8; pen_q <= 1'b0; odd_q <= 1'b0;
      buf_q <= '0; full_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
    end else begin
      st_q <= st_d; sub_q <= sub_d; vote_q <= vote_d; idx_q <= idx_d;
      dat_q <= dat_d; pb_q <= pb_d; len_q <= len_d; pen_q <= pen_d; odd_q <= odd_d;
      buf_q <= buf_d; full_q <= full_d; fe_q <= fe_d; pe_q <= pe_d;
    end
  end

  assign rx_word = buf_q;
  assign full    = full_q;
  assign ferr    = fe_q;
  assign perr    = pe_q;

endmodule

// File: rtl/sfx_xcvr.sv
module sfx_xcvr #(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_dbl,
  input  logic [3:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic             wr_stb,
  input  logic [7:0]       wr_byte,
  input  logic             ninth_wr,
  input  logic             ninth_in,
  input  logic             txdone_clr,
  input  logic             rd_stb,
  output logic [7:0]       rd_byte,
  output logic             rd_ninth,
  output logic             tx_empty,
  output logic             tx_done,
  output logic             rx_full,
  output logic             err_frame,
  output logic             err_parity,
  output logic             txd,
  input  logic             rxd
);

  logic       rst_a_q, rst_q;
  logic       tick, tx_busy, rx_fin;
  logic [8:0] tx_hold, rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_q   <= rst_a_q;
    end
  end

  sfx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_q), .div(cfg_div), .tick(tick)
  );

  sfx_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_q), .tick(tick), .dbl(cfg_dbl), .len(cfg_len),
    .pen(cfg_par_en), .odd(cfg_par_odd), .two(cfg_two_stop),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .ninth_wr(ninth_wr), .ninth_in(ninth_in),
    .done_clr(txdone_clr), .txd(txd), .empty(tx_empty), .done(tx_done),
    .busy(tx_busy), .hold_o(tx_hold)
  );

  sfx_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_q), .tick(tick), .dbl(cfg_dbl), .len(cfg_len),
    .pen(cfg_par_en), .odd(cfg_par_odd), .rxd(rxd), .rd_stb(rd_stb),
    .rx_word(rx_word), .full(rx_full), .ferr(err_frame), .perr(err_parity),
    .fin(rx_fin)
  );

  assign rd_byte  = rx_word[7:0];
  assign rd_ninth = rx_word[8];

endmodule

// File: rtl/sfx_chk.sv
module sfx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       tx_empty,
  input logic [8:0] hold,
  input logic       txd,
  input logic       tx_done,
  input logic       tx_busy,
  input logic       rd_stb,
  input logic       rx_fin,
  input logic       rx_full,
  input logic       par_en,
  input logic       err_parity
);

  AST_WRITE_WHEN_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !tx_empty) |=> $stable(hold));                              // R4
  AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_empty) |=> !tx_empty);                                   // R4
  AST_DONE_RISES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (tx_empty && txd && !tx_busy));                     // R6
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> !tx_done);                                              // R6
  AST_FINISH_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fin |=> rx_full);                                                   // R7
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rx_fin) |=> !rx_full);                                     // R11
  AST_NO_PARITY_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fin && !par_en) |=> !err_parity);                                  // R10

endmodule

bind sfx_xcvr sfx_chk u_chk (
  .clk(clk), .rst_n(rst_q), .wr_stb(wr_stb), .tx_empty(tx_empty), .hold(tx_hold),
  .txd(txd), .tx_done(tx_done), .tx_busy(tx_busy), .rd_stb(rd_stb),
  .rx_fin(rx_fin), .rx_full(rx_full), .par_en(cfg_par_en), .err_parity(err_parity)
);

// File: tb/sim_sfx_xcvr.sv
module sim_sfx_xcvr;

  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] cfg_div;
  logic        cfg_dbl, cfg_par_en, cfg_par_odd, cfg_two_stop;
  logic [3:0]  cfg_len;
  logic        wr_stb, ninth_wr, ninth_in, txdone_clr, rd_stb;
  logic [7:0]  wr_byte, rd_byte;
  logic        rd_ninth, tx_empty, tx_done, rx_full, err_frame, err_parity, txd, rxd;
  logic        lb, drv;

  int errs  = 0;
  int total = 0;
  bit fin_flag = 1'b0;

  always #2.5 clk = ~clk;
  assign rxd = lb ? txd : drv;

  sfx_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_dbl(cfg_dbl), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .ninth_wr(ninth_wr), .ninth_in(ninth_in),
    .txdone_clr(txdone_clr), .rd_stb(rd_stb), .rd_byte(rd_byte), .rd_ninth(rd_ninth),
    .tx_empty(tx_empty), .tx_done(tx_done), .rx_full(rx_full), .err_frame(err_frame),
    .err_parity(err_parity), .txd(txd), .rxd(rxd)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int bitp();
    return (cfg_dbl ? 8 : 16) * (DIV + 1);
  endfunction

  // Expected frame, LSB first: start, data, parity, stops
  function automatic int mkf(input int len, input bit pen, input bit odd, input int d,
                             input bit two, input bit flip, output int nb);
    int f = 0;
    int k = 1;
    bit p = odd;
    for (int i = 0; i < len; i++) begin
      f |= ((d >> i) & 1) << k;
      p ^= 1'((d >> i) & 1);
      k++;
    end
    if (pen) begin f |= int'(p ^ flip) << k; k++; end
    f |= 1 << k; k++;
    if (two) begin f |= 1 << k; k++; end
    nb = k;
    return f;
  endfunction

  task automatic set_cfg(input int len, input int par, input bit two, input bit dbl);
    cfg_len = 4'(len); cfg_par_en = (par != 0); cfg_par_odd = (par == 2);
    cfg_two_stop = two; cfg_dbl = dbl;
  endtask

  task automatic wr(input int b);
    wr_byte = 8'(b); wr_stb = 1'b1; cyc(1); wr_stb = 1'b0;
  endtask

  task automatic put_ninth(input bit v);
    ninth_in = v; ninth_wr = 1'b1; cyc(1); ninth_wr = 1'b0;
  endtask

  task automatic rd();
    rd_stb = 1'b1; cyc(1); rd_stb = 1'b0;
  endtask

  task automatic wait_rx(input int lim);
    int n = 0;
    while (!rx_full && n < lim) begin cyc(1); n++; end
  endtask

  task automatic drive_raw(input int f, input int nb, input int p);
    lb = 1'b0;
    for (int i = 0; i < nb; i++) begin drv = 1'((f >> i) & 1); cyc(p); end
    drv = 1'b1;
  endtask

  // Loopback frame: check line bits, tx_done, received word and flags
  task automatic send_check(input int len, input int par, input bit two, input bit dbl,
                            input int d);
    int nb, expf, got, p, n;
    lb = 1'b1;
    set_cfg(len, par, two, dbl);
    p    = bitp();
    expf = mkf(len, par != 0, par == 2, d, two, 1'b0, nb);
    put_ninth(1'((d >> 8) & 1));
    wr(d & 255);
    n = 0;
    while (txd && n < 2000) begin cyc(1); n++; end
    cyc(p / 2);
    got = 0;
    for (int i = 0; i < nb; i++) begin
      got |= int'(txd) << i;
      if (i < nb - 1) cyc(p);
    end
    check_eq(par != 0 ? "R3 frame with parity" : "R2 frame bits", got, expf);
    cyc(p / 2 + 3);
    check_eq("R6 tx_done after last stop", int'(tx_done), 1);
    wait_rx(3 * p);
    check_eq("R7 rx_full", int'(rx_full), 1);
    check_eq("R7 received word", {23'd0, rd_ninth, rd_byte},
             d & ((1 << len) - 1));
    check_eq("R9 no frame error", int'(err_frame), 0);
    check_eq("R10 no parity error", int'(err_parity), 0);
    rd();
    check_eq("R11 read clears rx_full", int'(rx_full), 0);
    txdone_clr = 1'b1; cyc(1); txdone_clr = 1'b0;
  endtask

  initial begin
    int f, nb, p;
    rst_n = 1'b0; lb = 1'b1; drv = 1'b1; cfg_div = 12'(DIV);
    set_cfg(8, 0, 1'b0, 1'b0);
    wr_stb = 0; wr_byte = 0; ninth_wr = 0; ninth_in = 0; txdone_clr = 0; rd_stb = 0;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    check_eq("R1 txd idle", int'(txd), 1);
    check_eq("R1 tx_empty", int'(tx_empty), 1);
    check_eq("R1 flags", {27'd0, tx_done, rx_full, err_frame, err_parity}, 0);

    // Sweep every frame shape in both speeds
    for (int dbl = 0; dbl < 2; dbl++)
      for (int len = 5; len <= 9; len++)
        for (int par = 0; par < 3; par++)
          for (int two = 0; two < 2; two++)
            send_check(len, par, 1'(two), 1'(dbl),
                       (len * 53 + par * 29 + two * 71 + dbl * 13 + 'h1A5) & 511);

    // R5: ninth bit captured at data write, later update has no effect
    lb = 1'b1; set_cfg(9, 0, 1'b0, 1'b0);
    put_ninth(1'b1); wr('h5A); put_ninth(1'b0);
    wait_rx(20 * bitp());
    check_eq("R5 ninth bit kept", int'(rd_ninth), 1);
    check_eq("R5 low byte", int'(rd_byte), 'h5A);
    rd();

    // R4/R6: second write accepted once hold empties, third ignored
    set_cfg(8, 0, 1'b0, 1'b0);
    txdone_clr = 1'b1; cyc(1); txdone_clr = 1'b0;
    wr('h3C);
    begin int n = 0; while (!tx_empty && n < 20) begin cyc(1); n++; end end
    wr('hC3);
    check_eq("R4 hold full after write", int'(tx_empty), 0);
    wr('h99);
    wait_rx(15 * bitp());
    check_eq("R4 first char", int'(rd_byte), 'h3C);
    rd();
    check_eq("R6 no tx_done between frames", int'(tx_done), 0);
    wait_rx(15 * bitp());
    check_eq("R4 second char", int'(rd_byte), 'hC3);
    rd();
    cyc(20 * bitp());
    check_eq("R4 ignored write sent nothing", int'(rx_full), 0);
    check_eq("R6 tx_done at end", int'(tx_done), 1);
    txdone_clr = 1'b1; cyc(1); txdone_clr = 1'b0;
    check_eq("R6 tx_done cleared", int'(tx_done), 0);

    // R8: short low pulse is not a start bit
    p = bitp();
    lb = 1'b0; drv = 1'b0; cyc(3 * (DIV + 1)); drv = 1'b1;
    cyc(2 * 11 * p);
    check_eq("R8 glitch rejected", int'(rx_full), 0);

    // R10: wrong even parity
    set_cfg(8, 1, 1'b0, 1'b0);
    f = mkf(8, 1'b1, 1'b0, 'h55, 1'b0, 1'b1, nb);
    drive_raw(f, nb, p); wait_rx(4 * p);
    check_eq("R10 parity error flagged", int'(err_parity), 1);
    check_eq("R10 byte still delivered", int'(rd_byte), 'h55);
    rd();

    // R9: low stop bit
    set_cfg(8, 0, 1'b0, 1'b0);
    f = mkf(8, 1'b0, 1'b0, 'hA7, 1'b0, 1'b0, nb);
    f &= ~(1 << (nb - 1));
    drive_raw(f, nb, p); wait_rx(4 * p);
    check_eq("R9 frame error flagged", int'(err_frame), 1);
    rd();
    cyc(2 * 11 * p);
    check_eq("R9 no extra char after bad stop", int'(rx_full), 0);

    // R9: receiver ignores two-stop setting
    set_cfg(8, 0, 1'b1, 1'b0);
    f = mkf(8, 1'b0, 1'b0, 'h81, 1'b0, 1'b0, nb);
    drive_raw(f, nb, p);
    f = mkf(8, 1'b0, 1'b0, 'h7E, 1'b0, 1'b0, nb);
    drive_raw(f, nb, p); wait_rx(4 * p);
    check_eq("R9 back-to-back one stop byte", int'(rd_byte), 'h7E);
    check_eq("R9 back-to-back no frame error", int'(err_frame), 0);
    rd();

    fin_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin_flag) begin
      errs++; total++;
      $display("FAIL watchdog: actual=0 expected=1 (run finished)");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

endmodule